// File: doc/BRIEF.md
# Sense-Reversing Barrier Synchronizer

This block gathers a fixed group of P participants at a barrier and lets them all proceed together once the last one has arrived. Each participant owns one arrive strobe and one release output. An arrival that is accepted increments an internal count and records a private sense bit. That sense bit is the opposite of the shared flag at the moment of arrival. The participant then waits for as long as its private sense differs from the shared flag.

When the count reaches P, the shared flag is inverted and the count returns to zero. This one inversion matches every private sense at once, so every waiter is freed in the same cycle. The flag is never cleared by a newcomer. A participant that leaves and arrives again before the slower ones have noticed their release therefore joins the next instance and does not cancel the one that just finished.

A combinational all-arrived output behaves like a wired-AND line. It is high in the cycle in which every participant is either already waiting or is arriving.

Top module: `sense_barrier`

## Requirements
- R1: After reset, release_o is all zero, waiting_o is all zero and flag_o is 0. No release occurs until arrivals are seen.
- R2: Each arrive_i strobe from a participant that is not waiting is accepted at the clock edge and counted. Strobes from several participants in the same cycle are all counted in that cycle.
- R3: All bits of release_o go high together for exactly one cycle: the cycle that follows the edge at which the P-th arrival of the instance was accepted. release_o is never high at any other time.
- R4: flag_o inverts once at each completed instance, and the change becomes visible in the same cycle as the release pulse. Its value therefore alternates 0, 1, 0, ... over successive instances.
- R5: waiting_o[i] is high from the cycle after participant i's accepted arrival until the barrier completes. It is low in the release cycle.
- R6: An arrive_i[i] strobe while waiting_o[i] is high has no effect. It changes neither the count nor the release timing.
- R7: A participant that strobes in its release cycle is accepted into the next instance. It is waiting in the following cycle, and that instance completes only when all P have arrived again.
- R8: all_in_o is high exactly when every bit of (waiting_o | arrive_i) is set, which is the condition that completes the barrier at the next edge.
- R9: With at most P-1 distinct participants arrived, no release occurs, however long the wait and however many repeated strobes arrive.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| arrive_i | input | P | One arrival strobe per participant, sampled each clock |
| release_o | output | P | One-cycle release pulse per participant |
| waiting_o | output | P | High while the participant is held at the barrier |
| flag_o | output | 1 | Shared sense flag |
| all_in_o | output | 1 | All participants arrived (wired-AND style) |

## Verification
The assertions assume two things about the inputs. First, rst_n is held low over at least one rising edge before use. Second, arrive_i is a level that is valid at each rising edge, with no pulse shorter than a cycle carrying meaning. The bench meets both by holding reset for several edges and by changing arrive_i only on falling edges. Within that, the stimulus exercises the following patterns:
- arrivals one at a time;
- all participants arriving in one cycle;
- long runs of repeated strobes from participants that are already waiting;
- re-entry in the release cycle;
- long random streams.

// File: rtl/sense_barrier.sv
module sense_barrier #(
  parameter int P = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [P-1:0] arrive_i,
  output logic [P-1:0] release_o,
  output logic [P-1:0] waiting_o,
  output logic         flag_o,
  output logic         all_in_o
);
  localparam int CW = $clog2(P + 1);

  logic [P-1:0] lsense;
  logic         gflag;
  logic [CW-1:0] cnt;
  logic         relq;

  function automatic logic [CW:0] pop(input logic [P-1:0] v);
    logic [CW:0] s;
    s = '0;
    for (int k = 0; k < P; k++) s = s + {{CW{1'b0}}, v[k]};
    return s;
  endfunction

  logic [P-1:0] acc;
  logic [CW:0]  sum;
  logic         done;

  assign waiting_o = lsense ^ {P{gflag}};
  assign acc       = arrive_i & ~waiting_o;
  assign sum       = {1'b0, cnt} + pop(acc);
  assign done      = (sum == (CW+1)'(P));
  assign release_o = {P{relq}};
  assign flag_o    = gflag;
  assign all_in_o  = &(waiting_o | arrive_i);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lsense <= '0;
      gflag  <= 1'b0;
      cnt    <= '0;
      relq   <= 1'b0;
    end else begin
      relq <= done;
      for (int i = 0; i < P; i++)
        if (acc[i]) lsense[i] <= ~gflag;
      if (done) begin
        gflag <= ~gflag;
        cnt   <= '0;
      end else begin
        cnt <= sum[CW-1:0];
      end
    end
  end

  assert_count_tracks_waiters_R2: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt) == $countones(waiting_o));

  assert_release_all_or_none_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (release_o == '0) || (&release_o));

  assert_release_after_all_in_R3: assert property (@(posedge clk) disable iff (!rst_n)
    all_in_o |=> (&release_o));

  assert_no_early_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !all_in_o |=> (release_o == '0));

  assert_flag_flips_with_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
    release_o[0] |-> (flag_o != $past(flag_o)));

  assert_flag_holds_otherwise_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !all_in_o |=> $stable(flag_o));

  assert_nobody_waits_on_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
    release_o[0] |-> ((waiting_o & ~$past(arrive_i)) == '0));

  for (genvar g = 0; g < P; g++) begin : g_chk
    assert_arrival_accepted_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!waiting_o[g] && arrive_i[g]) |=> (waiting_o[g] || release_o[g]));

    assert_extra_strobe_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (waiting_o[g] && !all_in_o) |=> (waiting_o[g] && $stable(lsense[g])));
  end
endmodule

// File: tb/sense_barrier_tb.sv
module sense_barrier_tb_top;
  localparam int P = 4;
  localparam time CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [P-1:0] arrive = '0;
  logic [P-1:0] rel, wt;
  logic flag, allin;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit finished = 0;

  bit [P-1:0] m_wait;
  int         m_cnt;
  bit         m_flag;
  bit         m_rel;

  always #(CLK_PERIOD/2) clk = ~clk;

  sense_barrier #(.P(P)) dut_i (
    .clk(clk), .rst_n(rst_n), .arrive_i(arrive),
    .release_o(rel), .waiting_o(wt), .flag_o(flag), .all_in_o(allin)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      m_wait <= '0; m_cnt <= 0; m_flag <= 0; m_rel <= 0;
    end else begin
      bit [P-1:0] a;
      int n;
      a = arrive & ~m_wait;
      n = m_cnt + $countones(a);
      if (n == P) begin
        m_cnt <= 0; m_wait <= '0; m_flag <= ~m_flag; m_rel <= 1;
      end else begin
        m_cnt <= n; m_wait <= m_wait | a; m_rel <= 0;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    #1;
    if (rst_n && !finished) begin
      chk(rel == {P{m_rel}}, "R3", "release", 32'(rel), 32'({P{m_rel}}));
      chk(flag == m_flag, "R4", "flag", 32'(flag), 32'(m_flag));
      chk(wt == m_wait, "R5", "waiting", 32'(wt), 32'(m_wait));
      chk(allin == &(m_wait | arrive), "R8", "all_in", 32'(allin), 32'(&(m_wait | arrive)));
    end
  end

  task automatic step(input logic [P-1:0] a);
    @(negedge clk);
    arrive = a;
  endtask

  task automatic finish_run;
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=%0d expected<150000", cyc);
      finish_run();
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    #2;
    // R1: reset state
    chk(rel == '0, "R1", "release after reset", 32'(rel), 0);
    chk(wt == '0, "R1", "waiting after reset", 32'(wt), 0);
    chk(flag == 1'b0, "R1", "flag after reset", 32'(flag), 0);

    // R2/R3: one at a time
    for (int i = 0; i < P; i++) step(4'(1 << i));
    step('0);
    #2 chk(rel == '1, "R3", "release one cycle after last", 32'(rel), 32'({P{1'b1}}));
    chk(flag == 1'b1, "R4", "flag after first instance", 32'(flag), 1);
    step('0);

    // R2: all in one cycle
    step('1);
    step('0);
    #2 chk(rel == '1, "R2", "simultaneous arrivals release", 32'(rel), 32'({P{1'b1}}));
    chk(flag == 1'b0, "R4", "flag alternates back", 32'(flag), 0);

    // R6/R9: repeated strobes from P-1 waiters
    step(4'b0111);
    for (int k = 0; k < 20; k++) begin
      step(4'b0111);
      #2 chk(rel == '0, "R9", "no release with P-1 arrived", 32'(rel), 0);
      chk(wt == 4'b0111, "R6", "extra strobes ignored", 32'(wt), 32'(4'b0111));
    end
    step(4'b1000);
    step(4'b0001); // release cycle: early re-entry by participant 0
    #2 chk(rel == '1, "R3", "release after final arrival", 32'(rel), 32'({P{1'b1}}));
    step('0);
    #2 chk(wt == 4'b0001, "R7", "re-entrant waiting in next instance", 32'(wt), 1);
    chk(rel == '0, "R7", "no second release", 32'(rel), 0);
    step(4'b1110);
    step('0);
    #2 chk(rel == '1, "R7", "next instance completes", 32'(rel), 32'({P{1'b1}}));

    // random stream
    for (int k = 0; k < 3000; k++) begin
      logic [P-1:0] a;
      for (int b = 0; b < P; b++) a[b] = ($urandom_range(0, 99) < 30);
      step(a);
    end
    step('0);
    step('0);
    finish_run();
  end
endmodule